// File: doc/BRIEF.md
# Integer ALU with signed overflow detection

This block performs the integer arithmetic, logic, compare and shift work of a 32-bit RISC execute stage. It takes two operands, a separate shift-amount field and an operation code. It returns a 32-bit result and a flag that marks signed overflow. The pipeline uses that flag to raise an exception. Immediate extension happens upstream, so an immediate reaches the block already widened into operand B. Multiply, divide, the register file and the exception logic itself sit outside.

The combinational datapath has three parts: an adder/subtractor that also produces both orderings for set-less-than, a barrel shifter, and a bitwise logic unit. A single result register follows them. That register sits behind a valid/ready handshake on both sides:
- An operation is taken on a cycle where `in_valid` and `in_ready` are both high.
- Its result is presented one cycle later with `out_valid`.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-to-back operations run at one per clock.
- While `out_valid` is high and `out_ready` is low, the result and the flag are held unchanged and no new operation is accepted.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (trapping add) and 2 (trapping subtract, A minus B) return the 32-bit wrapped result. They raise `out_ovf` exactly when the two inputs of the effective addition share a sign and the sum's sign differs from it.
- R2: Codes 1 (non-trapping add) and 3 (non-trapping subtract) return the same wrapped sums as codes 0 and 2, and `out_ovf` is always 0 for them.
- R3: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B), bitwise.
- R4: Code 8 returns 1 when A is less than B as two's complement numbers, else 0. This holds even when A minus B overflows.
- R5: Code 9 returns 1 when A is less than B as unsigned numbers, else 0.
- R6: Codes 10, 11 and 12 shift operand B by `in_shamt`: left with zero fill, right with zero fill, and right with copies of bit 31.
- R7: Codes 13, 14 and 15 shift operand B left, right-logical and right-arithmetic. The amount comes from the low 5 bits of operand A only, and `in_shamt` is ignored.
- R8: Code 16 returns the low 16 bits of B in bits 31:16, with bits 15:0 zero.
- R9: An operation accepted on a clock edge appears on `out_result`/`out_ovf` with `out_valid` after that edge. `in_ready` is high when `out_valid` is low or `out_ready` is high. A stalled output keeps its value, and results leave in the order they were accepted.
- R10: After reset, `out_valid` is 0 and `out_ovf` is 0.
- R11: Codes 17 to 31 return zero with `out_ovf` 0.
- R12: `out_ovf` is 0 for every code other than 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 5 | Operation code (see requirements) |
| in_a | input | 32 | Operand A; variable shift amount in bits 4:0 |
| in_b | input | 32 | Operand B; value that shifts and upper-immediate move |
| in_shamt | input | 5 | Fixed shift amount |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result |
| out_ovf | output | 1 | Signed overflow for the trapping add/subtract |

## Verification
The block's two functions that can share a cycle are draining a held result and accepting the next operation. This happens when `out_ready` and `in_valid` are both high while `out_valid` is set. The bench provokes it by streaming operations back to back while the consumer pulls with a periodic stall pattern, so some cycles stall and others overlap a drain with a new accept. The scoreboard judges it by popping exactly one expected item per drained result and comparing value, flag and order. A lost, repeated or corrupted result during the overlap shows as a mismatch or as a leftover queue entry.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_SLL  = 5'd10,
    OP_SRL  = 5'd11,
    OP_SRA  = 5'd12,
    OP_SLLV = 5'd13,
    OP_SRLV = 5'd14,
    OP_SRAV = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith import int_alu_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] sum,
  output logic         ovf_raw,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  logic         sub;
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  always_comb begin
    sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
    b_eff = b ^ {W{sub}};
    total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = total[W-1:0];
    // same-sign inputs, different-sign sum
    ovf_raw     = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    lt_signed   = sum[W-1] ^ ovf_raw;
    lt_unsigned = ~total[W];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   res
);
  logic [W-1:0] stage [SHW+1];
  logic         fill;
  logic [W-1:0] out_r;

  always_comb begin
    fill = arith & ~left & val[W-1];
    for (int i = 0; i < W; i++) stage[0][i] = left ? val[W-1-i] : val[i];
  end

  generate
    for (genvar g = 0; g < SHW; g++) begin : g_stage
      localparam int D = 1 << g;
      always_comb begin
        if (amt[g]) stage[g+1] = {{D{fill}}, stage[g][W-1:D]};
        else        stage[g+1] = stage[g];
      end
    end
  endgenerate

  always_comb begin
    out_r = stage[SHW];
    for (int i = 0; i < W; i++) res[i] = left ? out_r[W-1-i] : out_r[i];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic import int_alu_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOR:  res = ~(a | b);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu import int_alu_pkg::*; #(
  parameter  int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [SHW-1:0]  in_shamt,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            out_ovf
);
  localparam int HW = W / 2;

  alu_op_e        op;
  logic [W-1:0]   sum, logic_res, shift_res;
  logic           ovf_raw, lt_s, lt_u;
  logic [SHW-1:0] sh_amt;
  logic           sh_left, sh_arith, variable_sh;
  logic [W-1:0]   res_d;
  logic           ovf_d;
  logic           accept;

  assign op = alu_op_e'(in_op);

  alu_arith #(.W(W)) u_arith (
    .a(in_a), .b(in_b), .op(op), .sum(sum),
    .ovf_raw(ovf_raw), .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  alu_logic #(.W(W)) u_logic (.a(in_a), .b(in_b), .op(op), .res(logic_res));

  always_comb begin
    variable_sh = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
    sh_left     = (op == OP_SLL)  || (op == OP_SLLV);
    sh_arith    = (op == OP_SRA)  || (op == OP_SRAV);
    sh_amt      = variable_sh ? in_a[SHW-1:0] : in_shamt;
  end

  alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .val(in_b), .amt(sh_amt), .left(sh_left), .arith(sh_arith), .res(shift_res)
  );

  always_comb begin
    ovf_d = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin res_d = sum; ovf_d = ovf_raw; end
      OP_ADDU, OP_SUBU: res_d = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR: res_d = logic_res;
      OP_SLT:  res_d = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: res_d = {{(W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: res_d = shift_res;
      OP_LUI:  res_d = {in_b[HW-1:0], {HW{1'b0}}};
      default: res_d = '0;
    endcase
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= res_d;
        out_ovf    <= ovf_d;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk import int_alu_pkg::*; #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_op,
  input logic [W-1:0]    in_a,
  input logic [W-1:0]    in_b,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_result,
  input logic            out_ovf
);
  logic fire;
  assign fire = in_valid && in_ready;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_ovf));

  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == OP_ADDU || in_op == OP_SUBU) |=> !out_ovf);

  a_r12_flag_only_trap: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !(in_op == OP_ADD || in_op == OP_SUB) |=> !out_ovf);

  a_r3_nor: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == OP_NOR |=> out_result == ~($past(in_a) | $past(in_b)));

  a_r4_compare_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == OP_SLT || in_op == OP_SLTU) |=> out_result[W-1:1] == '0);

  a_r8_upper_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == OP_LUI |=> out_result[W/2-1:0] == '0);

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op > OP_LUI |=> out_result == '0 && !out_ovf);
endmodule

bind int_alu int_alu_chk #(.W(W), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_ovf(out_ovf)
);

// File: tb/sim_int_alu.sv
`timescale 1ns/1ps
module sim_int_alu;
  typedef struct {
    logic [31:0] res;
    logic        ovf;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [4:0]  in_op = 0;
  logic [31:0] in_a = 0, in_b = 0;
  logic [4:0]  in_shamt = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [31:0] out_result;
  logic        out_ovf;

  int   errors = 0, checks = 0;
  int   stall_mode = 0;
  int   cyc = 0;
  bit   done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  int_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_ovf(out_ovf)
  );

  function automatic string tag_of(input logic [4:0] op);
    if (op == 0 || op == 2) return "R1";
    if (op == 1 || op == 3) return "R2";
    if (op >= 4 && op <= 7) return "R3";
    if (op == 8)  return "R4";
    if (op == 9)  return "R5";
    if (op >= 10 && op <= 12) return "R6";
    if (op >= 13 && op <= 15) return "R7";
    if (op == 16) return "R8";
    return "R11";
  endfunction

  function automatic exp_t model(input logic [4:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [4:0] sh);
    exp_t e;
    longint s;
    e.res = 0; e.ovf = 0; e.tag = tag_of(op);
    case (op)
      0, 1: begin
        e.res = a + b;
        s = longint'($signed(a)) + longint'($signed(b));
        if (op == 0) e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      2, 3: begin
        e.res = a - b;
        s = longint'($signed(a)) - longint'($signed(b));
        if (op == 2) e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4: e.res = a & b;
      5: e.res = a | b;
      6: e.res = a ^ b;
      7: e.res = ~(a | b);
      8: e.res = ($signed(a) < $signed(b)) ? 1 : 0;
      9: e.res = (a < b) ? 1 : 0;
      10: e.res = b << sh;
      11: e.res = b >> sh;
      12: e.res = $unsigned($signed(b) >>> sh);
      13: e.res = b << a[4:0];
      14: e.res = b >> a[4:0];
      15: e.res = $unsigned($signed(b) >>> a[4:0]);
      16: e.res = {b[15:0], 16'h0};
      default: e.res = 0;
    endcase
    return e;
  endfunction

  task automatic send(input logic [4:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [4:0] sh);
    sb.push_back(model(op, a, b, sh));
    @(negedge clk);
    in_valid = 1; in_op = op; in_a = a; in_b = b; in_shamt = sh;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  // consumer / monitor
  always @(negedge clk) begin
    exp_t e;
    cyc = cyc + 1;
    if (rst_n) begin
      out_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      #1;
      if (out_valid && out_ready) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected result %h (expected none)", out_result);
        end else begin
          e = sb.pop_front();
          if (out_result !== e.res || out_ovf !== e.ovf) begin
            errors++;
            $display("FAIL %s: got res=%h ovf=%b expected res=%h ovf=%b",
                     e.tag, out_result, out_ovf, e.res, e.ovf);
          end
        end
      end
    end
  end

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || out_ovf !== 0) begin
      errors++;
      $display("FAIL R10: out_valid=%b out_ovf=%b expected 0 0", out_valid, out_ovf);
    end
    @(negedge clk) rst_n = 1;

    // R1 trapping add / subtract corners
    send(0, 32'h7fffffff, 32'h1, 0);
    send(0, 32'h80000000, 32'hffffffff, 0);
    send(0, 32'h5, 32'hfffffffd, 0);
    send(2, 32'h80000000, 32'h1, 0);
    send(2, 32'h7fffffff, 32'hffffffff, 0);
    send(2, 32'h3, 32'h5, 0);
    // R2 non-trapping
    send(1, 32'h7fffffff, 32'h1, 0);
    send(3, 32'h80000000, 32'h1, 0);
    send(3, 32'h0, 32'h1, 0);
    // R3 logic
    send(4, 32'hf0f0ff00, 32'h3c3c0ff0, 0);
    send(5, 32'hf0f0ff00, 32'h3c3c0ff0, 0);
    send(6, 32'hf0f0ff00, 32'h3c3c0ff0, 0);
    send(7, 32'hf0f0ff00, 32'h3c3c0ff0, 0);
    // R4 / R5 compares, including overflowing difference and equality
    send(8, 32'hffffffff, 32'h1, 0);
    send(9, 32'hffffffff, 32'h1, 0);
    send(8, 32'h7fffffff, 32'h80000000, 0);
    send(8, 32'h80000000, 32'h7fffffff, 0);
    send(8, 32'h1234, 32'h1234, 0);
    send(9, 32'h1, 32'h2, 0);
    send(9, 32'h2, 32'h2, 0);
    // R6 fixed shifts
    send(10, 32'h0, 32'h8000000f, 4);
    send(11, 32'h0, 32'h80000000, 31);
    send(12, 32'h0, 32'h80000000, 31);
    send(12, 32'h0, 32'h40000000, 30);
    send(10, 32'h0, 32'h12345678, 0);
    // R7 variable shifts: amount from low bits of A, shamt ignored
    send(15, 32'h00000023, 32'h80000010, 7);
    send(13, 32'hffffffe1, 32'h80000001, 9);
    send(14, 32'h0000003f, 32'hffffffff, 2);
    send(14, 32'hffffff00, 32'h80000000, 31);
    // R8 upper immediate
    send(16, 32'hffffffff, 32'h1234abcd, 0);
    // R11 / R12 unused codes
    send(20, 32'h7fffffff, 32'h1, 0);
    send(31, 32'hffffffff, 32'hffffffff, 31);

    // R9 back-pressure with back-to-back traffic
    stall_mode = 1;
    r = 32'h1badcafe;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      r = xs(r); a = r;
      r = xs(r); b = r;
      if (i % 7 == 0) b = a ^ 32'h80000000;
      send(5'(i % 18), a, b, r[9:5]);
    end
    stall_mode = 0;

    repeat (20) @(posedge clk);
    #1;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing, expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9: watchdog expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule